// File: doc/BRIEF.md
# Machine Cycle Bus Sequencer

This block runs one processor bus transaction at a time through a fixed series of clock states: an opening state that announces the cycle, an address state, any number of inserted wait states, and a closing state. In the opening state it raises a one-clock framing pulse and drives a status byte on the data lines. It then either opens the data lines for input or drives write data under an active-low write strobe, until the transaction completes. A slow target holds off completion by keeping `ready` low.

An external bus master can take the address and data lines by raising `hold`. The sequencer grants the bus only at defined points. The grant acknowledge rises in the closing state of a read, and one clock later for a write, so that write data is never cut short. The bus can also be granted at once while the core is halted. While the grant is active, every line driver is switched off through the two output-enable signals. I/O transactions copy the 8-bit port number onto every byte of the address bus.

A request is a one-clock pulse on `req_valid` while the sequencer is idle. Instruction decode and register storage are outside this block.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `sync`, `dbin`, `wait_o`, `hlda`, `addr_oe`, `data_oe` and `cyc_done` are 0, `wr_n` is 1, and the sequencer is idle.
- R2: One clock after a request is accepted, the opening state lasts exactly one clock. In that state `sync`=1, `data_oe`=1, `addr_oe`=1, `data_out` equals the request's status byte and `addr_out` carries the request address.
- R3: For a read, `dbin`=1 in the address state and in every wait state, and 0 otherwise. `data_oe` is 0 whenever `dbin` is 1. `rd_capture` equals `dbin` AND `ready`.
- R4: When `ready` is 0 at the end of the address state or of a wait state, the next clock is a wait state with `wait_o`=1. The first clock with `ready`=1 at its edge moves on to the closing state.
- R5: For a write, `wr_n` is 0 from the address state through the closing state. During that time `data_oe`=1 and `data_out` holds the write data unchanged.
- R6: `hold` is taken into account only at the end of the address state or of a wait state with `ready`=1, or while idle with `halted`=1. A `hold` seen at any other time has no effect.
- R7: When `hold` is recognised during a read, `hlda` rises in the closing state, in the same clock as `cyc_done`. During a write it rises one clock after the closing state.
- R8: While `hlda`=1, `addr_oe`=0 and `data_oe`=0.
- R9: When `hold` is 0 at a clock edge in the granted state, `hlda` is 0 from that edge on and the sequencer is idle. A new request is then accepted.
- R10: For an I/O request (`req_io`=1), each 8-bit byte of `addr_out` equals `req_addr[7:0]`. For a memory request, `addr_out` equals `req_addr`.
- R11: `req_valid` is ignored unless the sequencer is idle. `cyc_done` is 1 for exactly the one closing-state clock of each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start-transaction pulse, sampled only while idle |
| req_write | input | 1 | 1 = write/output, 0 = read/input |
| req_io | input | 1 | 1 = I/O port transaction |
| req_status | input | DATA_W | Status byte driven in the opening state |
| req_addr | input | ADDR_W | Memory address or port number in the low byte |
| req_wdata | input | DATA_W | Write data |
| ready | input | 1 | Target ready; 0 inserts wait states |
| hold | input | 1 | External master bus request |
| halted | input | 1 | Core is halted |
| addr_out | output | ADDR_W | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_out | output | DATA_W | Registered data bus value |
| data_oe | output | 1 | Data bus drive enable |
| sync | output | 1 | Opening-state framing pulse |
| dbin | output | 1 | Data bus in input mode |
| wr_n | output | 1 | Active-low write strobe |
| wait_o | output | 1 | Wait state indicator |
| hlda | output | 1 | Bus grant acknowledge |
| rd_capture | output | 1 | Read data may be captured this clock |
| cyc_done | output | 1 | Closing state of the transaction |

## Verification
The bench builds the block with its default widths: a 16-bit address, 8-bit data and an 8-bit port number. With these widths the I/O mirroring gives two identical address bytes, and a port value whose upper and lower halves differ shows any byte that fails to mirror. Wait-state runs of two clocks cover the TW-to-TW loop. Grants are exercised on reads, on writes, with `ready` low, and from the halted idle state, so each grant timing branch is reached.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       hold_rec;
    } fsm_regs_t;
endpackage

// File: rtl/bcs_fsm.sv
`timescale 1ns/1ps
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ready,
    input  logic       hold,
    input  logic       halted,
    output seq_state_e st,
    output logic       hold_rec,
    output logic       take
);
    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        take  = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                fsm_d.hold_rec = 1'b0;
                if (halted && hold) begin
                    fsm_d.st = ST_HOLD;
                end else if (start) begin
                    fsm_d.st = ST_T1;
                    take     = 1'b1;
                end
            end
            ST_T1: fsm_d.st = ST_T2;
            ST_T2, ST_TW: begin
                if (ready) begin
                    fsm_d.st       = ST_T3;
                    fsm_d.hold_rec = hold;
                end else begin
                    fsm_d.st = ST_TW;
                end
            end
            ST_T3: fsm_d.st = fsm_q.hold_rec ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!hold) begin
                    fsm_d.st       = ST_IDLE;
                    fsm_d.hold_rec = 1'b0;
                end
            end
            default: fsm_d = '{st: ST_IDLE, hold_rec: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, hold_rec: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign st       = fsm_q.st;
    assign hold_rec = fsm_q.hold_rec;
endmodule

// File: rtl/bcs_latch.sv
`timescale 1ns/1ps
module bcs_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              to_addr_state,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_status,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] dout_q
);
    localparam int REP = ADDR_W / PORT_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] dout;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [ADDR_W-1:0] port_addr;

    // Port number copied onto every byte lane of the address bus
    for (genvar g = 0; g < REP; g++) begin : g_mirror
        assign port_addr[g*PORT_W +: PORT_W] = req_addr[PORT_W-1:0];
    end

    always_comb begin
        lat_d = lat_q;
        if (take) begin
            lat_d.wr    = req_write;
            lat_d.addr  = req_io ? port_addr : req_addr;
            lat_d.wdata = req_wdata;
            lat_d.dout  = req_status;
        end else if (to_addr_state && lat_q.wr) begin
            lat_d.dout  = lat_q.wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign write_q = lat_q.wr;
    assign addr_q  = lat_q.addr;
    assign dout_q  = lat_q.dout;
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_status,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold,
    input  logic              halted,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              sync,
    output logic              dbin,
    output logic              wr_n,
    output logic              wait_o,
    output logic              hlda,
    output logic              rd_capture,
    output logic              cyc_done
);
    seq_state_e st;
    logic hold_rec, take, write_q;
    logic in_xfer, in_bus;

    bcs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_valid),
        .ready    (ready),
        .hold     (hold),
        .halted   (halted),
        .st       (st),
        .hold_rec (hold_rec),
        .take     (take)
    );

    bcs_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_lat (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .to_addr_state (st == ST_T1),
        .req_write     (req_write),
        .req_io        (req_io),
        .req_status    (req_status),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .write_q       (write_q),
        .addr_q        (addr_out),
        .dout_q        (data_out)
    );

    assign in_xfer    = (st == ST_T2) || (st == ST_TW);
    assign in_bus     = (st == ST_T1) || in_xfer || (st == ST_T3);
    assign hlda       = (st == ST_HOLD) || ((st == ST_T3) && hold_rec && !write_q);
    assign addr_oe    = in_bus && !hlda;
    assign data_oe    = !hlda && ((st == ST_T1) ||
                        (write_q && (in_xfer || (st == ST_T3))));
    assign sync       = (st == ST_T1);
    assign dbin       = !write_q && in_xfer;
    assign wr_n       = !(write_q && (in_xfer || (st == ST_T3)));
    assign wait_o     = (st == ST_TW);
    assign rd_capture = dbin && ready;
    assign cyc_done   = (st == ST_T3);
endmodule

// File: rtl/bcs_chk.sv
`timescale 1ns/1ps
module bcs_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              hold,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              sync,
    input logic              dbin,
    input logic              wr_n,
    input logic              wait_o,
    input logic              hlda,
    input logic              cyc_done
);
    // R2
    sync_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (data_oe && addr_oe && !dbin && wr_n));
    // R2
    sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !sync);
    // R3
    dbin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbin |-> (!data_oe && wr_n));
    // R4
    wait_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && !ready) |=> wait_o);
    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> data_oe);
    // R5
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_n || $stable(data_out)));
    // R7
    hlda_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hlda) && cyc_done) |-> wr_n);
    // R8
    float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!addr_oe && !data_oe));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold && !cyc_done) |=> !hlda);
    // R11
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);
endmodule

bind bus_cycle_seq bcs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .hold     (hold),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .data_out (data_out),
    .data_oe  (data_oe),
    .sync     (sync),
    .dbin     (dbin),
    .wr_n     (wr_n),
    .wait_o   (wait_o),
    .hlda     (hlda),
    .cyc_done (cyc_done)
);

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [7:0]  req_status = '0, req_wdata = '0;
    logic [15:0] req_addr = '0;
    logic        ready = 1'b1, hold = 1'b0, halted = 1'b0;
    logic [15:0] addr_out;
    logic [7:0]  data_out;
    logic        addr_oe, data_oe, sync, dbin, wr_n, wait_o, hlda, rd_capture, cyc_done;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_status(req_status), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .hold(hold), .halted(halted),
        .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out),
        .data_oe(data_oe), .sync(sync), .dbin(dbin), .wr_n(wr_n),
        .wait_o(wait_o), .hlda(hlda), .rd_capture(rd_capture), .cyc_done(cyc_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic issue(input logic wr, input logic io, input logic [7:0] st,
                         input logic [15:0] a, input logic [7:0] wd);
        req_write = wr; req_io = io; req_status = st; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 sync", sync, 0);      chk("R1 dbin", dbin, 0);
        chk("R1 wr_n", wr_n, 1);      chk("R1 wait", wait_o, 0);
        chk("R1 hlda", hlda, 0);      chk("R1 addr_oe", addr_oe, 0);
        chk("R1 data_oe", data_oe, 0); chk("R1 done", cyc_done, 0);
    endtask

    task automatic t_read;
        ready = 1'b1;
        issue(1'b0, 1'b0, 8'hA2, 16'h1234, 8'h00);
        chk("R2 sync", sync, 1);
        chk("R2 status", data_out, 8'hA2);
        chk("R2 data_oe", data_oe, 1);
        chk("R10 mem addr", addr_out, 16'h1234);
        step();
        chk("R2 one clock", sync, 0);
        chk("R3 dbin T2", dbin, 1);
        chk("R3 capture", rd_capture, 1);
        chk("R3 data_oe off", data_oe, 0);
        step();
        chk("R11 done", cyc_done, 1);
        chk("R3 dbin T3", dbin, 0);
        step();
        chk("R11 done one clock", cyc_done, 0);
        chk("R1 idle addr_oe", addr_oe, 0);
    endtask

    task automatic t_write_wait;
        ready = 1'b0;
        issue(1'b1, 1'b0, 8'h10, 16'hBEEF, 8'h5C);
        chk("R2 write status", data_out, 8'h10);
        step();
        chk("R5 wr_n T2", wr_n, 0);
        chk("R5 data T2", data_out, 8'h5C);
        chk("R4 no wait in T2", wait_o, 0);
        chk("R3 no dbin on write", dbin, 0);
        step();
        chk("R4 wait 1", wait_o, 1);
        chk("R5 wr_n TW", wr_n, 0);
        step();
        chk("R4 wait 2", wait_o, 1);
        chk("R5 data TW", data_out, 8'h5C);
        ready = 1'b1;
        step();
        chk("R4 leave wait", wait_o, 0);
        chk("R5 wr_n T3", wr_n, 0);
        chk("R5 data_oe T3", data_oe, 1);
        chk("R11 done write", cyc_done, 1);
        step();
        chk("R5 wr_n released", wr_n, 1);
    endtask

    task automatic t_read_wait;
        ready = 1'b0;
        issue(1'b0, 1'b0, 8'h82, 16'h0040, 8'h00);
        step();
        chk("R3 dbin T2 wait", dbin, 1);
        chk("R3 no capture", rd_capture, 0);
        step();
        chk("R4 read wait", wait_o, 1);
        chk("R3 dbin TW", dbin, 1);
        ready = 1'b1;
        #1;
        chk("R3 capture TW", rd_capture, 1);
        step();
        chk("R11 done after wait", cyc_done, 1);
        step();
    endtask

    task automatic t_hold_read;
        ready = 1'b1;
        issue(1'b0, 1'b0, 8'h82, 16'h0100, 8'h00);
        hold = 1'b1;
        step();
        chk("R6 no grant T2", hlda, 0);
        step();
        chk("R7 read hlda at T3", hlda, 1);
        chk("R7 done same clock", cyc_done, 1);
        chk("R8 addr float", addr_oe, 0);
        step();
        chk("R7 held", hlda, 1);
        chk("R8 data float", data_oe, 0);
        hold = 1'b0;
        step();
        chk("R9 hlda drop", hlda, 0);
        issue(1'b0, 1'b0, 8'h82, 16'h0200, 8'h00);
        chk("R9 resume", sync, 1);
        step(); step(); step();
    endtask

    task automatic t_hold_write;
        ready = 1'b1;
        issue(1'b1, 1'b0, 8'h00, 16'h0300, 8'h3E);
        hold = 1'b1;
        step();
        step();
        chk("R7 write no hlda T3", hlda, 0);
        chk("R5 write still driven", data_oe, 1);
        chk("R5 wr_n T3 hold", wr_n, 0);
        step();
        chk("R7 write hlda after T3", hlda, 1);
        chk("R8 float write", data_oe, 0);
        chk("R8 addr float write", addr_oe, 0);
        hold = 1'b0;
        step();
        chk("R9 write release", hlda, 0);
    endtask

    task automatic t_hold_not_ready;
        ready = 1'b0;
        issue(1'b0, 1'b0, 8'h82, 16'h0400, 8'h00);
        hold = 1'b1;
        step();
        step();
        chk("R6 in TW", wait_o, 1);
        hold = 1'b0;
        ready = 1'b1;
        step();
        chk("R6 not-ready hold ignored", hlda, 0);
        chk("R6 T3 reached", cyc_done, 1);
        step();
        chk("R6 idle no grant", hlda, 0);
    endtask

    task automatic t_idle_hold;
        hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6 idle hold ignored", hlda, 0);
        end
        halted = 1'b1;
        step();
        chk("R6 halted grant", hlda, 1);
        chk("R8 halted float", addr_oe, 0);
        hold = 1'b0;
        step();
        chk("R9 halted release", hlda, 0);
        halted = 1'b0;
    endtask

    task automatic t_io;
        issue(1'b0, 1'b1, 8'h42, 16'h12AB, 8'h00);
        chk("R10 port mirror", addr_out, 16'hABAB);
        step(); step(); step();
    endtask

    task automatic t_ignore;
        ready = 1'b1;
        issue(1'b0, 1'b0, 8'h82, 16'h7777, 8'h00);
        step();
        req_addr = 16'h5555;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk("R11 addr kept", addr_out, 16'h7777);
        step();
        step();
        chk("R11 late request ignored", sync, 0);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step();
        t_reset();
        t_read();
        t_write_wait();
        t_read_wait();
        t_hold_read();
        t_hold_write();
        t_hold_not_ready();
        t_idle_hold();
        t_io();
        t_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule